// File: doc/BRIEF.md
# Multicast group address hash filter

This block sits on the receive side of an Ethernet MAC. It judges whether a frame whose destination address is a group address should be kept. The six destination bytes stream in one per cycle. As they arrive, a CRC-32 runs over them, least significant bit of each byte first. The eight high bits of the CRC then pick one bit of a 256-bit table, and that bit decides the frame.

Software owns the table. It is stored as eight 32-bit registers with a simple write port and a combinational read port, and all eight come out of reset as zero. A frame whose first byte has its group bit clear is never accepted by this block. Individual addresses are another filter's concern. The all-ones broadcast address is always accepted.

Top module: `mcast_hash_filter`

## Requirements
- R1: After reset all eight table registers read 0, `acceptValid` is 0 and `accept` is 0.
- R2: With `tblWrEn` high at a clock edge, `tblWrData` is stored in register `tblWrSel`. `tblRdData` always shows register `tblRdSel` combinationally.
- R3: The hash index is bits 31..24 of a CRC-32 with polynomial 0x04C11DB7 in shift-left form. The CRC is preset to all ones at the first byte, takes each byte's bit 0 first, and is not inverted at the end.
- R4: Index bits 7..5 choose the table register. Index bits 4..0 with value k choose bit 31-k of that register. The frame is accepted when that bit is 1.
- R5: A byte is taken at a clock edge where `byteValid` is high. `byteFirst` marks the first of six bytes. `acceptValid` is high for exactly the one cycle that follows the edge taking the sixth byte.
- R6: If bit 0 of the first byte is 0, `accept` is 0 for that frame, whatever the table holds.
- R7: The address made of six 0xFF bytes is accepted even with an empty table. An address differing from it in any bit follows the table.
- R8: If a table register is written at the same edge that takes the sixth byte, the lookup uses the register's old value.
- R9: `accept` keeps its value between results. Bytes with `byteValid` high that arrive while no frame is open (no `byteFirst` since the last result) are ignored.
- R10: A `byteFirst` byte that arrives in the middle of a frame abandons that frame and starts a new one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tblWrEn | input | 1 | Table register write strobe |
| tblWrSel | input | 3 | Register number to write |
| tblWrData | input | 32 | Write data |
| tblRdSel | input | 3 | Register number to read |
| tblRdData | output | 32 | Read data |
| byteValid | input | 1 | A destination-address byte is present |
| byteFirst | input | 1 | The present byte is the first of the address |
| addrByte | input | 8 | Destination-address byte |
| acceptValid | output | 1 | One-cycle pulse: `accept` is new |
| accept | output | 1 | Decision for the last complete address |

## Verification
The bench sweeps 64 multicast addresses. For each one it sets only the predicted table bit and expects accept, then sets every bit except that one and expects reject. A wrong bit order in the CRC, a reversed bit numbering inside a register, or a wrong register choice would each accept the wrong frames. Further cases cover a unicast address against a full table, which a filter ignoring the group bit would accept, and broadcast against an empty table next to a one-bit-off near-broadcast. The bench also writes the table in the same cycle as a lookup, which exposes a design that forwards the new value. Finally it sends stray and restarted byte streams, which a counter that fails to wait for `byteFirst`, or fails to reset on it, would count into a false result.

// File: rtl/mcast_filt_pkg.sv
package mcast_filt_pkg;
  // control-to-datapath strobes for one input byte
  typedef struct packed {
    logic take;   // byte belongs to an open or starting frame
    logic first;  // byte starts a frame (CRC preset)
    logic last;   // byte completes the address
  } strobe_t;

  localparam logic [31:0] CRC_POLY = 32'h04C11DB7;
endpackage

// File: rtl/mcast_filt_ctrl.sv
module mcast_filt_ctrl
  import mcast_filt_pkg::*;
#(
  parameter int ADDR_BYTES = 6
) (
  input  logic    clk,
  input  logic    rst_n,
  input  logic    byteValid,
  input  logic    byteFirst,
  output strobe_t strb
);
  localparam int CW = $clog2(ADDR_BYTES + 1);

  logic [CW-1:0] byteCnt;   // bytes taken in open frame, 0 = none open
  logic [CW-1:0] nextCnt;
  logic          frameOpen;

  always_comb begin
    frameOpen  = (byteCnt != '0);
    nextCnt    = byteFirst ? CW'(1) : byteCnt + CW'(1);
    strb.take  = byteValid & (byteFirst | frameOpen);
    strb.first = byteValid & byteFirst;
    strb.last  = strb.take & (nextCnt == CW'(ADDR_BYTES));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      byteCnt <= '0;
    end else if (strb.take) begin
      byteCnt <= strb.last ? '0 : nextCnt;
    end
  end
endmodule

// File: rtl/mcast_filt_dp.sv
module mcast_filt_dp
  import mcast_filt_pkg::*;
#(
  parameter int IDX_BITS = 8,
  parameter int REG_W    = 32,
  localparam int NUM_REGS = (1 << IDX_BITS) / REG_W,
  localparam int RSEL_W   = $clog2(NUM_REGS),
  localparam int BSEL_W   = $clog2(REG_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  strobe_t           strb,
  input  logic [7:0]        addrByte,
  input  logic              tblWrEn,
  input  logic [RSEL_W-1:0] tblWrSel,
  input  logic [REG_W-1:0]  tblWrData,
  input  logic [RSEL_W-1:0] tblRdSel,
  output logic [REG_W-1:0]  tblRdData,
  output logic              acceptValid,
  output logic              accept
);
  logic [REG_W-1:0]    tableArr [NUM_REGS];
  logic [31:0]         crcReg;
  logic [31:0]         crcNext;
  logic                grpReg;
  logic                bcastReg;
  logic [IDX_BITS-1:0] hashIdx;
  logic [RSEL_W-1:0]   regSel;
  logic [BSEL_W-1:0]   bitSel;
  logic                tableHit;
  logic                grpNow;
  logic                bcastNow;

  // byte-wide CRC step, bit 0 of the byte first
  always_comb begin
    logic [31:0] c;
    logic        fb;
    c = strb.first ? '1 : crcReg;
    for (int b = 0; b < 8; b++) begin
      fb = c[31] ^ addrByte[b];
      c  = {c[30:0], 1'b0} ^ (fb ? CRC_POLY : 32'h0);
    end
    crcNext = c;
  end

  always_comb begin
    hashIdx  = crcNext[31 -: IDX_BITS];
    regSel   = hashIdx[IDX_BITS-1 -: RSEL_W];
    bitSel   = BSEL_W'(REG_W - 1) - hashIdx[BSEL_W-1:0];   // entry 0 -> MSB
    tableHit = tableArr[regSel][bitSel];
    grpNow   = strb.first ? addrByte[0] : grpReg;
    bcastNow = (strb.first | bcastReg) & (addrByte == 8'hFF);
    tblRdData = tableArr[tblRdSel];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int r = 0; r < NUM_REGS; r++) tableArr[r] <= '0;
    end else if (tblWrEn) begin
      tableArr[tblWrSel] <= tblWrData;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      crcReg      <= '1;
      grpReg      <= 1'b0;
      bcastReg    <= 1'b0;
      acceptValid <= 1'b0;
      accept      <= 1'b0;
    end else begin
      acceptValid <= strb.last;
      if (strb.take) begin
        crcReg   <= crcNext;
        grpReg   <= grpNow;
        bcastReg <= bcastNow;
      end
      if (strb.last) accept <= grpNow & (bcastNow | tableHit);
    end
  end
endmodule

// File: rtl/mcast_hash_filter.sv
module mcast_hash_filter
  import mcast_filt_pkg::*;
#(
  parameter int ADDR_BYTES = 6,
  parameter int IDX_BITS   = 8,
  parameter int REG_W      = 32,
  localparam int NUM_REGS  = (1 << IDX_BITS) / REG_W,
  localparam int RSEL_W    = $clog2(NUM_REGS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tblWrEn,
  input  logic [RSEL_W-1:0] tblWrSel,
  input  logic [REG_W-1:0]  tblWrData,
  input  logic [RSEL_W-1:0] tblRdSel,
  output logic [REG_W-1:0]  tblRdData,
  input  logic              byteValid,
  input  logic              byteFirst,
  input  logic [7:0]        addrByte,
  output logic              acceptValid,
  output logic              accept
);
  strobe_t strb;

  mcast_filt_ctrl #(.ADDR_BYTES(ADDR_BYTES)) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .byteValid(byteValid), .byteFirst(byteFirst),
    .strb(strb)
  );

  mcast_filt_dp #(.IDX_BITS(IDX_BITS), .REG_W(REG_W)) u_dp (
    .clk(clk), .rst_n(rst_n), .strb(strb), .addrByte(addrByte),
    .tblWrEn(tblWrEn), .tblWrSel(tblWrSel), .tblWrData(tblWrData),
    .tblRdSel(tblRdSel), .tblRdData(tblRdData),
    .acceptValid(acceptValid), .accept(accept)
  );
endmodule

// File: rtl/mcast_filt_chk.sv
module mcast_filt_chk #(
  parameter int RSEL_W = 3,
  parameter int REG_W  = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              tblWrEn,
  input logic [RSEL_W-1:0] tblWrSel,
  input logic [REG_W-1:0]  tblWrData,
  input logic [RSEL_W-1:0] tblRdSel,
  input logic [REG_W-1:0]  tblRdData,
  input logic              byteValid,
  input logic              byteFirst,
  input logic [7:0]        addrByte,
  input logic              acceptValid,
  input logic              accept
);
  logic grpSeen;
  logic allOnes;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      grpSeen <= 1'b0;
      allOnes <= 1'b0;
    end else if (byteValid) begin
      if (byteFirst) begin
        grpSeen <= addrByte[0];
        allOnes <= (addrByte == 8'hFF);
      end else begin
        allOnes <= allOnes & (addrByte == 8'hFF);
      end
    end
  end

  AST_WR_READBACK: assert property (@(posedge clk) disable iff (!rst_n)
    tblWrEn |=> ((tblRdSel != $past(tblWrSel)) || (tblRdData == $past(tblWrData)))); // R2
  AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    acceptValid |=> !acceptValid); // R5
  AST_VALID_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    acceptValid |-> $past(byteValid)); // R5
  AST_UNICAST_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
    (acceptValid && !grpSeen) |-> !accept); // R6
  AST_BCAST_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (acceptValid && allOnes) |-> accept); // R7
  AST_ACCEPT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !acceptValid |-> $stable(accept)); // R9
endmodule

bind mcast_hash_filter mcast_filt_chk #(.RSEL_W(RSEL_W), .REG_W(REG_W)) u_chk (.*);

// File: tb/mcast_hash_filter_bench.sv
module mcast_hash_filter_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tblWrEn = 1'b0;
  logic [2:0]  tblWrSel = '0;
  logic [31:0] tblWrData = '0;
  logic [2:0]  tblRdSel = '0;
  logic [31:0] tblRdData;
  logic        byteValid = 1'b0;
  logic        byteFirst = 1'b0;
  logic [7:0]  addrByte = '0;
  logic        acceptValid;
  logic        accept;

  int  nChecks = 0;
  int  nErrors = 0;
  bit  finished = 1'b0;
  logic [7:0] frm [6];
  logic       gotValid, gotAcc;

  always #(CLK_PERIOD/2) clk = ~clk;

  mcast_hash_filter u_mcast_hash_filter (.*);

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nErrors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // reflected-form CRC: index bit 7-i equals register bit i
  function automatic logic [7:0] refIdx();
    logic [31:0] r = 32'hFFFF_FFFF;
    logic [7:0]  idx;
    for (int k = 0; k < 6; k++)
      for (int b = 0; b < 8; b++)
        r = (r >> 1) ^ ((r[0] ^ frm[k][b]) ? 32'hEDB8_8320 : 32'h0);
    for (int i = 0; i < 8; i++) idx[7-i] = r[i];
    return idx;
  endfunction

  task automatic wrReg(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); tblWrEn = 1'b1; tblWrSel = a; tblWrData = d;
    @(negedge clk); tblWrEn = 1'b0;
  endtask

  task automatic fillAll(input logic [31:0] d);
    for (int r = 0; r < 8; r++) wrReg(3'(r), d);
  endtask

  task automatic sendFrame();
    for (int k = 0; k < 6; k++) begin
      @(negedge clk); byteValid = 1'b1; byteFirst = (k == 0); addrByte = frm[k];
    end
    @(negedge clk); byteValid = 1'b0; byteFirst = 1'b0;
    gotValid = acceptValid; gotAcc = accept;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nErrors++;
      $display("FAIL watchdog actual=%h expected=%h", 0, 1);
      $display("CHECKS %0d ERRORS %0d", nChecks, nErrors);
      $finish;
    end
  end

  initial begin
    logic [7:0] idx;
    logic [31:0] bitMask;
    repeat (3) @(negedge clk);
    // R1: reset state
    for (int r = 0; r < 8; r++) begin
      tblRdSel = 3'(r); #1;
      check(tblRdData == 0, "R1 table reset", tblRdData, 0);
    end
    check(acceptValid == 0 && accept == 0, "R1 outputs reset", {acceptValid, accept}, 0);
    rst_n = 1'b1;

    // R2: write/read each register
    for (int r = 0; r < 8; r++) wrReg(3'(r), 32'hA5000000 ^ (32'(r) * 32'h01010101));
    for (int r = 0; r < 8; r++) begin
      tblRdSel = 3'(r); #1;
      check(tblRdData == (32'hA5000000 ^ (32'(r) * 32'h01010101)), "R2 readback",
            tblRdData, 32'hA5000000 ^ (32'(r) * 32'h01010101));
    end
    fillAll(32'h0);

    // R3/R4/R5: sweep of multicast addresses
    for (int i = 0; i < 64; i++) begin
      frm = '{8'h01, 8'h00, 8'h5E, 8'(i * 37), 8'(i * 11 + 3), 8'(i ^ 8'h5A)};
      idx = refIdx();
      bitMask = 32'h1 << (31 - idx[4:0]);
      wrReg(idx[7:5], bitMask);
      sendFrame();
      check(gotValid == 1, "R5 valid after sixth byte", gotValid, 1);
      check(gotAcc == 1, "R3 R4 selected bit accepts", gotAcc, 1);
      @(negedge clk);
      check(acceptValid == 0, "R5 one-cycle pulse", acceptValid, 0);
      fillAll(32'hFFFF_FFFF);
      wrReg(idx[7:5], ~bitMask);
      sendFrame();
      check(gotAcc == 0, "R4 other bits do not accept", gotAcc, 0);
      fillAll(32'h0);
    end

    // R6: unicast never accepted
    fillAll(32'hFFFF_FFFF);
    frm = '{8'h02, 8'h11, 8'h22, 8'h33, 8'h44, 8'h55};
    sendFrame();
    check(gotValid == 1 && gotAcc == 0, "R6 unicast rejected", {gotValid, gotAcc}, 2'b10);
    fillAll(32'h0);

    // R7: broadcast and near-broadcast on empty table
    frm = '{8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'hFF};
    sendFrame();
    check(gotAcc == 1, "R7 broadcast accepted", gotAcc, 1);
    frm = '{8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'hFE};
    sendFrame();
    check(gotAcc == 0, "R7 near-broadcast follows table", gotAcc, 0);

    // R8: write in the lookup cycle sees old value
    frm = '{8'h01, 8'h80, 8'hC2, 8'h00, 8'h00, 8'h0E};
    idx = refIdx();
    wrReg(idx[7:5], 32'h1 << (31 - idx[4:0]));
    for (int k = 0; k < 6; k++) begin
      @(negedge clk); byteValid = 1'b1; byteFirst = (k == 0); addrByte = frm[k];
      if (k == 5) begin tblWrEn = 1'b1; tblWrSel = idx[7:5]; tblWrData = 32'h0; end
    end
    @(negedge clk); byteValid = 1'b0; tblWrEn = 1'b0;
    check(acceptValid == 1 && accept == 1, "R8 old value used", {acceptValid, accept}, 2'b11);
    sendFrame();
    check(gotAcc == 0, "R8 new value next frame", gotAcc, 0);

    // R9: hold and stray bytes ignored
    frm = '{8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'hFF};
    sendFrame();
    for (int k = 0; k < 8; k++) begin
      @(negedge clk); byteValid = 1'b1; byteFirst = 1'b0; addrByte = 8'h00;
    end
    @(negedge clk); byteValid = 1'b0;
    @(negedge clk);
    check(acceptValid == 0 && accept == 1, "R9 strays ignored, accept held",
          {acceptValid, accept}, 2'b01);

    // R10: restart mid-frame
    for (int k = 0; k < 3; k++) begin
      @(negedge clk); byteValid = 1'b1; byteFirst = (k == 0); addrByte = 8'h33;
    end
    @(negedge clk); byteValid = 1'b0;
    check(acceptValid == 0, "R10 partial frame gives no result", acceptValid, 0);
    frm = '{8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'hFE};
    sendFrame();
    check(gotValid == 1 && gotAcc == 0, "R10 restarted frame decides", {gotValid, gotAcc}, 2'b10);

    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", nChecks, nErrors);
    $finish;
  end
endmodule